// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it holds every strobe inactive for a long power-up pause. It then runs a fixed number of CAS-before-RAS (CBR) refresh cycles without asking for the bus, and after that it raises `init_done`. From then on, a free-running interval timer adds one owed refresh every refresh interval. The sequencer asks the access controller for the bus through `refresh_req` and pays back its debt only when `grant` is high in an idle cycle. Because of this, refreshes can wait while a page stays open. When the debt reaches its ceiling, `refresh_urgent` is raised so that the controller can give the sequencer top priority.

A self-refresh request uses the same grant. The sequencer enters in CBR order and holds RAS low for at least the minimum self-refresh time, and for as long as the request stays high. It then applies the longer self-refresh precharge before it hands the bus back. RAS is therefore never held low for a time between a normal refresh pulse and the self-refresh minimum. The `STROBE_USE` parameter picks which CAS strobes take part, because dropping just one strobe already selects the refresh mode. All timings are given in nanoseconds and converted to clock cycles by rounding up.

Top module: `dref_sequencer`

## Requirements
- R1: From reset, `ras_n`, `cas_lo_n` and `cas_hi_n` stay high, `busy` stays high and `init_done` stays low for PWR_CYC = ceil(PWRUP_NS/CLK_PERIOD_NS) clock cycles. The first CAS drop happens on clock edge PWR_CYC after reset release. Reset is asynchronous and returns the block to this state at once.
- R2: After the pause, exactly INIT_CYCLES CBR cycles run without any grant. `init_done` rises, and `busy` falls, on the same edge where the last precharge ends.
- R3: In every CBR cycle, the enabled CAS strobes go low CSR_CYC cycles before RAS. RAS then stays low for RAS_CYC cycles and the CAS strobes rise together with it. All strobes then stay high for RP_CYC cycles of precharge.
- R4: After `init_done`, the owed count rises by one every TREF_CYC cycles and falls by one for each completed refresh. It saturates at OWED_MAX. `refresh_req` is high whenever the count is non-zero.
- R5: `refresh_urgent` is high exactly when the owed count equals OWED_MAX.
- R6: After init, a refresh or self-refresh entry starts only on an edge where `grant` is high while the sequencer is idle. With `grant` low, all strobes stay high however much is owed.
- R7: `STROBE_USE` bit 0 enables `cas_lo_n` and bit 1 enables `cas_hi_n`. A strobe whose bit is 0 stays high at all times.
- R8: When the sequencer is idle, granted, and `self_req` is high, it enters self refresh in CBR order (CAS first for CSR_CYC cycles). It then holds RAS low for at least SELF_MIN_CYC cycles, and longer until `self_req` is sampled low. Self refresh has priority over owed refreshes.
- R9: After self-refresh RAS rises, `busy` stays high with all strobes high for RPS_CYC cycles, and the sequencer then returns to idle.
- R10: Every RAS low pulse lasts either exactly RAS_CYC cycles or at least SELF_MIN_CYC cycles.
- R11: Self refresh clears the owed count and the interval timer. `refresh_req` is low on return to idle, and the next tick comes TREF_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| grant | input | 1 | Bus granted to the sequencer by the access controller |
| self_req | input | 1 | Level request to enter and stay in self refresh |
| refresh_req | output | 1 | Sequencer wants the bus (refresh owed or self refresh requested) |
| refresh_urgent | output | 1 | Owed count at its ceiling; top priority needed |
| init_done | output | 1 | Power-up sequence complete; normal accesses allowed |
| busy | output | 1 | Sequencer owns and drives the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower-byte column strobe, active low |
| cas_hi_n | output | 1 | Upper-byte column strobe, active low |

## Verification
The bench builds the sequencer with a 20 ns clock, a 400 ns pause (20 cycles), a 1000 ns refresh interval (50 cycles), a 600 ns self-refresh minimum (30 cycles), 110 ns self-refresh precharge (6 cycles), an owed ceiling of 3, and `STROBE_USE` = 2'b01. With these short values, debt saturation, the urgent flag and both self-refresh exit cases (minimum-limited and request-limited) each occur within a few hundred cycles. A single lower strobe shows the one-strobe refresh selection, and the upper strobe is watched to confirm it never moves.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    ST_PWR,   // power-up pause, strobes idle
    ST_CAS,   // CBR: CAS low, RAS high
    ST_RAS,   // CBR: CAS and RAS low
    ST_PRE,   // normal precharge
    ST_IDLE,  // bus released
    ST_SCAS,  // self-refresh entry: CAS first
    ST_SELF,  // self refresh: RAS and CAS held low
    ST_SPRE   // long precharge after self refresh
  } seq_st_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic ras_on(input seq_st_e s);
    return (s == ST_RAS) || (s == ST_SELF);
  endfunction

  function automatic logic cas_on(input seq_st_e s);
    return (s == ST_CAS) || (s == ST_RAS) || (s == ST_SCAS) || (s == ST_SELF);
  endfunction

endpackage

// File: rtl/dref_phase_timer.sv
module dref_phase_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= W'(RST_VAL);
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dref_interval.sv
module dref_interval #(
  parameter int unsigned TICK_CYC = 780,
  parameter int unsigned OWED_MAX = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             run,
  input  logic                             clear,
  input  logic                             served,
  output logic [$clog2(OWED_MAX+1)-1:0]    owed,
  output logic                             saturated
);
  localparam int unsigned TW = $clog2(TICK_CYC + 1);
  localparam int unsigned OW = $clog2(OWED_MAX + 1);

  logic [TW-1:0] tcnt_q;
  logic          tick;
  logic          inc, dec;

  assign tick = run && (tcnt_q == TW'(TICK_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tcnt_q <= '0;
    else if (clear)  tcnt_q <= '0;
    else if (run)    tcnt_q <= tick ? '0 : tcnt_q + 1'b1;
  end

  assign inc = tick && (owed != OW'(OWED_MAX));
  assign dec = served && (owed != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           owed <= '0;
    else if (clear)       owed <= '0;
    else if (inc && !dec) owed <= owed + 1'b1;
    else if (dec && !inc) owed <= owed - 1'b1;
  end

  assign saturated = (owed == OW'(OWED_MAX));

  // R4: the debt never passes its ceiling
  assert_owed_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(OWED_MAX))
    else $error("owed count above ceiling");

  // R4: the debt moves by one step at a time, or is cleared
  assert_owed_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owed != $past(owed)) |->
      ((owed == $past(owed) + 1) || (owed + 1 == $past(owed)) || (owed == '0)))
    else $error("owed count jumped");
endmodule

// File: rtl/dref_strobe_drv.sv
module dref_strobe_drv
  import dref_pkg::*;
#(
  parameter logic [1:0] STROBE_USE = 2'b11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seq_st_e    nxt,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n <= 1'b1;
      busy  <= 1'b1;
    end else begin
      ras_n <= !ras_on(nxt);
      busy  <= (nxt != ST_IDLE);
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    if (STROBE_USE[g]) begin : g_used
      logic lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= 1'b1;
        else        lane_q <= !cas_on(nxt);
      end
      assign cas_n[g] = lane_q;
    end else begin : g_idle
      assign cas_n[g] = 1'b1;
    end
  end
endmodule

// File: rtl/dref_sequencer.sv
module dref_sequencer
  import dref_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned PWRUP_NS      = 200_000,
  parameter int unsigned TREF_NS       = 15_600,
  parameter int unsigned CSR_NS        = 5,
  parameter int unsigned RAS_NS        = 60,
  parameter int unsigned RP_NS         = 40,
  parameter int unsigned RPS_NS        = 110,
  parameter int unsigned SELF_MIN_NS   = 100_000,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned OWED_MAX      = 8,
  parameter logic [1:0]  STROBE_USE    = 2'b11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic self_req,
  output logic refresh_req,
  output logic refresh_urgent,
  output logic init_done,
  output logic busy,
  output logic ras_n,
  output logic cas_lo_n,
  output logic cas_hi_n
);
  localparam int unsigned PWR_CYC      = ns_to_cyc(PWRUP_NS, CLK_PERIOD_NS);
  localparam int unsigned TREF_CYC     = ns_to_cyc(TREF_NS, CLK_PERIOD_NS);
  localparam int unsigned CSR_CYC      = ns_to_cyc(CSR_NS, CLK_PERIOD_NS);
  localparam int unsigned RAS_CYC      = ns_to_cyc(RAS_NS, CLK_PERIOD_NS);
  localparam int unsigned RP_CYC       = ns_to_cyc(RP_NS, CLK_PERIOD_NS);
  localparam int unsigned RPS_CYC      = ns_to_cyc(RPS_NS, CLK_PERIOD_NS);
  localparam int unsigned SELF_MIN_CYC = ns_to_cyc(SELF_MIN_NS, CLK_PERIOD_NS);
  localparam int unsigned LONGEST      = max_u(max_u(PWR_CYC, SELF_MIN_CYC),
                                               max_u(RPS_CYC, RAS_CYC));
  localparam int unsigned TW           = $clog2(LONGEST + 1);
  localparam int unsigned IW           = $clog2(INIT_CYCLES + 1);
  localparam int unsigned OW           = $clog2(OWED_MAX + 1);

  seq_st_e       state_q, state_d;
  logic          tmr_load, expired;
  logic [TW-1:0] tmr_val;
  logic [IW-1:0] init_cnt_q;
  logic          init_done_q;
  logic [OW-1:0] owed;
  logic          saturated;
  logic [1:0]    cas_n;

  // named internal events
  logic refresh_served, init_step, init_last, self_span, start_cycle;

  assign init_step      = (state_q == ST_PRE) && expired && !init_done_q;
  assign init_last      = init_step && (init_cnt_q == IW'(INIT_CYCLES - 1));
  assign refresh_served = (state_q == ST_PRE) && expired && init_done_q;
  assign self_span      = (state_q == ST_SCAS) || (state_q == ST_SELF) ||
                          (state_q == ST_SPRE);
  assign start_cycle    = (state_q == ST_IDLE) && (state_d != ST_IDLE);

  dref_phase_timer #(.W(TW), .RST_VAL(PWR_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(expired)
  );

  dref_interval #(.TICK_CYC(TREF_CYC), .OWED_MAX(OWED_MAX)) u_interval (
    .clk(clk), .rst_n(rst_n), .run(init_done_q && !self_span),
    .clear(self_span), .served(refresh_served), .owed(owed),
    .saturated(saturated)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_PWR: if (expired) begin
        state_d = ST_CAS;  tmr_load = 1'b1; tmr_val = TW'(CSR_CYC - 1);
      end
      ST_CAS: if (expired) begin
        state_d = ST_RAS;  tmr_load = 1'b1; tmr_val = TW'(RAS_CYC - 1);
      end
      ST_RAS: if (expired) begin
        state_d = ST_PRE;  tmr_load = 1'b1; tmr_val = TW'(RP_CYC - 1);
      end
      ST_PRE: if (expired) begin
        if (init_step && !init_last) begin
          state_d = ST_CAS; tmr_load = 1'b1; tmr_val = TW'(CSR_CYC - 1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (grant && self_req) begin
          state_d = ST_SCAS; tmr_load = 1'b1; tmr_val = TW'(CSR_CYC - 1);
        end else if (grant && (owed != '0)) begin
          state_d = ST_CAS;  tmr_load = 1'b1; tmr_val = TW'(CSR_CYC - 1);
        end
      end
      ST_SCAS: if (expired) begin
        state_d = ST_SELF; tmr_load = 1'b1; tmr_val = TW'(SELF_MIN_CYC - 1);
      end
      ST_SELF: if (expired && !self_req) begin
        state_d = ST_SPRE; tmr_load = 1'b1; tmr_val = TW'(RPS_CYC - 1);
      end
      ST_SPRE: if (expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PWR;
      init_cnt_q  <= '0;
      init_done_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (init_step)  init_cnt_q  <= init_cnt_q + 1'b1;
      if (init_last)  init_done_q <= 1'b1;
    end
  end

  dref_strobe_drv #(.STROBE_USE(STROBE_USE)) u_drv (
    .clk(clk), .rst_n(rst_n), .nxt(state_d), .ras_n(ras_n), .cas_n(cas_n),
    .busy(busy)
  );

  assign cas_lo_n       = cas_n[0];
  assign cas_hi_n       = cas_n[1];
  assign init_done      = init_done_q;
  assign refresh_req    = init_done_q && ((owed != '0) || self_req);
  assign refresh_urgent = init_done_q && saturated;

  // ---------------------------------------------------------------- checks
  localparam int unsigned RW = $clog2(SELF_MIN_CYC + 2);
  logic [RW-1:0] ras_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ras_low_run <= '0;
    else if (ras_n)                        ras_low_run <= '0;
    else if (ras_low_run != RW'(SELF_MIN_CYC + 1)) ras_low_run <= ras_low_run + 1'b1;
  end

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWR) |-> (ras_n && cas_lo_n && cas_hi_n && busy && !init_done))
    else $error("strobe active during power-up pause");

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ((!cas_lo_n || !cas_hi_n) && $past(!cas_lo_n || !cas_hi_n)))
    else $error("RAS fell without CAS already low");

  assert_cas_with_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (cas_lo_n && cas_hi_n))
    else $error("CAS still low after RAS rose");

  assert_urgent_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_urgent |-> refresh_req)
    else $error("urgent without request");

  assert_start_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done) && $fell(cas_lo_n && cas_hi_n)) |-> $past(grant))
    else $error("cycle started without grant");

  assert_self_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SELF) && self_req) |=> !ras_n)
    else $error("self refresh left while still requested");

  assert_ras_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ((ras_low_run == RW'(RAS_CYC)) ||
                      (ras_low_run >= RW'(SELF_MIN_CYC))))
    else $error("RAS low width in forbidden window");

  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_cycle |-> grant)
    else $error("idle exit without grant");
endmodule

// File: tb/dref_sequencer_tb.sv
module dref_sequencer_tb;
  localparam int PWR_CYC = 20, RAS_CYC = 3, CSR_CYC = 1, RP_CYC = 2;
  localparam int RPS_CYC = 6, SELF_MIN_CYC = 30, TREF_CYC = 50, OWED_MAX = 3;
  localparam int INIT_CYCLES = 8;
  localparam int INIT_END = PWR_CYC + INIT_CYCLES * (CSR_CYC + RAS_CYC + RP_CYC);

  // owed-debt vectors: ticks waited, expected urgent, expected refreshes
  localparam int VEC_N = 4;
  localparam int VEC_TICKS [VEC_N] = '{1, 2, 3, 5};
  localparam int VEC_URG   [VEC_N] = '{0, 0, 1, 1};
  localparam int VEC_CNT   [VEC_N] = '{1, 2, 3, 3};

  logic clk = 1'b0, rst_n = 1'b0, grant = 1'b0, self_req = 1'b0;
  logic refresh_req, refresh_urgent, init_done, busy, ras_n, cas_lo_n, cas_hi_n;

  always #10 clk = ~clk;

  dref_sequencer #(
    .CLK_PERIOD_NS(20), .PWRUP_NS(400), .TREF_NS(1000), .CSR_NS(5),
    .RAS_NS(60), .RP_NS(40), .RPS_NS(110), .SELF_MIN_NS(600),
    .INIT_CYCLES(INIT_CYCLES), .OWED_MAX(OWED_MAX), .STROBE_USE(2'b01)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .self_req(self_req),
    .refresh_req(refresh_req), .refresh_urgent(refresh_urgent),
    .init_done(init_done), .busy(busy), .ras_n(ras_n),
    .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n)
  );

  int total = 0, fails = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // global monitors for R7 and R10
  int run_len = 0, bad_win = 0, hi_low = 0;
  always @(negedge clk) begin
    if (!rst_n) run_len = 0;
    else begin
      if (!cas_hi_n) hi_low++;
      if (!ras_n) run_len++;
      else begin
        if (run_len != 0 && !(run_len == RAS_CYC || run_len >= SELF_MIN_CYC)) bad_win++;
        run_len = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  task automatic drain();
    grant = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!refresh_req && !busy) break;
    end
    grant = 1'b0;
  endtask

  task automatic run_self(input int hold, output int low_len, output int pre_len);
    bit seen;
    seen = 0; low_len = 0; pre_len = 0;
    grant = 1'b1; self_req = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!ras_n) begin seen = 1; low_len++; end
      else if (seen) begin
        if (busy && ras_n && cas_lo_n) pre_len++;
        else break;
      end
      if (i == hold - 1) self_req = 1'b0;
    end
    grant = 1'b0;
  endtask

  initial begin
    int cyc, first_cas, lead, width, gap, falls, cnt, lo, pre, hi_req;
    bit quiet, prev;

    // reset state (R1)
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {ras_n, cas_lo_n, cas_hi_n}, 3'b111);
    chk("R1 reset busy", busy, 1);
    chk("R1 reset init_done", init_done, 0);
    chk("R4 reset refresh_req", refresh_req, 0);

    // power-up pause and init burst (R1, R2, R3)
    rst_n = 1'b1;
    cyc = 0; first_cas = -1; lead = 0; width = 0; gap = 0; falls = 0;
    quiet = 1; prev = 1;
    for (int i = 0; i < 400 && !init_done; i++) begin
      @(negedge clk); cyc++;
      if (first_cas < 0 && !cas_lo_n) first_cas = cyc;
      if (first_cas < 0 && (!ras_n || !busy || init_done)) quiet = 0;
      if (!ras_n && prev) falls++;
      if (falls == 0 && !cas_lo_n && ras_n) lead++;
      if (falls == 1 && !ras_n) width++;
      if (falls == 1 && ras_n && cas_lo_n && width > 0) gap++;
      prev = ras_n;
    end
    chk("R1 first CAS edge", first_cas, PWR_CYC);
    chk("R1 quiet pause", quiet, 1);
    chk("R3 CAS lead", lead, CSR_CYC);
    chk("R3 RAS width", width, RAS_CYC);
    chk("R3 precharge", gap, RP_CYC);
    chk("R2 init CBR count", falls, INIT_CYCLES);
    chk("R2 init_done edge", cyc, INIT_END);
    chk("R2 busy released", busy, 0);

    // no grant: no strobes (R6)
    cnt = 0;
    repeat (120) begin @(negedge clk); if (!ras_n || !cas_lo_n) cnt++; end
    chk("R6 strobes idle without grant", cnt, 0);
    chk("R4 request while owed", refresh_req, 1);

    // vector walk: debt accumulation and payback (R4, R5)
    for (int v = 0; v < VEC_N; v++) begin
      drain();
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (refresh_req) break; end
      repeat ((VEC_TICKS[v] - 1) * TREF_CYC + 10) @(negedge clk);
      chk("R5 urgent flag", refresh_urgent, VEC_URG[v]);
      grant = 1'b1; cnt = 0; prev = 1;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (!ras_n && prev) cnt++;
        prev = ras_n;
        if (!refresh_req && !busy) break;
      end
      grant = 1'b0;
      chk("R4 refreshes paid", cnt, VEC_CNT[v]);
    end

    // self refresh, minimum-limited (R8, R9, R11)
    drain();
    run_self(5, lo, pre);
    chk("R8 self RAS min width", lo, SELF_MIN_CYC);
    chk("R9 self precharge", pre, RPS_CYC);
    chk("R11 request cleared", refresh_req, 0);
    hi_req = 0;
    repeat (40) begin @(negedge clk); if (refresh_req) hi_req++; end
    chk("R11 timer restarted", hi_req, 0);
    hi_req = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (refresh_req) begin hi_req = 1; break; end end
    chk("R11 next tick arrives", hi_req, 1);

    // self refresh, request-limited (R8)
    drain();
    run_self(70, lo, pre);
    chk("R8 self held by request", lo, 69);
    chk("R9 self precharge long", pre, RPS_CYC);

    // reset during self refresh (R1)
    drain();
    grant = 1'b1; self_req = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 in self refresh", ras_n, 0);
    rst_n = 1'b0; #1;
    chk("R1 async reset strobes", {ras_n, cas_lo_n}, 2'b11);
    chk("R1 async reset init_done", init_done, 0);
    self_req = 1'b0; grant = 1'b0;
    repeat (2) @(negedge clk);

    chk("R7 unused strobe high", hi_low, 0);
    chk("R10 RAS window", bad_win, 0);
    summary();
  end
endmodule